// File: doc/BRIEF.md
# Linked-Reservation Atomic Word

This block is one shared data word that several requesters update through a single arbitrated request port. Every cycle at most one request is accepted and applied atomically: a plain read, a plain write, a load-linked, a store-conditional, a compare-and-swap or a test-and-set. Next to the data value the block keeps one reservation bit for each requester. A load-linked sets the caller's bit. Any operation that really changes the stored value wipes all bits. As a result, a store-conditional detects that the value was changed and then changed back (an A-B-A history), which a compare-and-swap cannot see.

Each requester has its own valid/ready request channel. A requester raises valid with its opcode and operands and holds all of them unchanged until the cycle in which ready is high. That cycle is the transfer. Ready depends on valid in the same cycle. It is high for at most one requester, chosen in round-robin order. Back-pressure exists only on the request side. The response channel has no ready: exactly one cycle after a transfer the block presents the success flag, the data and the requester index for one cycle, and the receiver must take them.

Top module: `linked_word_unit`

## Requirements
- R1: After synchronous reset (rst high at a clock edge) the word holds 0, every reservation bit is clear and rsp_valid is low until a request is accepted.
- R2: Opcodes are 3 bits: 0 read, 1 write, 2 load-linked, 3 store-conditional, 4 compare-and-swap, 5 test-and-set, and 6 and 7 act as read. A read returns ok=1 with the current word and changes no state.
- R3: A load-linked from requester p sets reservation bit p, leaves the word unchanged and returns ok=1 with the current word.
- R4: A store-conditional from p while bit p is set stores wdata, clears every reservation bit, and returns ok=1 with wdata. This holds even when wdata equals the current word.
- R5: A store-conditional from p while bit p is clear changes nothing and returns ok=0 with the current word.
- R6: A compare-and-swap stores wdata only when the word equals cmp. It returns ok=1 on a match and ok=0 otherwise, and in both cases returns the word as it was before the operation.
- R7: A test-and-set stores 1 and returns ok=1 only when the word is 0. Otherwise it changes nothing and returns ok=0. In both cases it returns the prior word.
- R8: A write stores wdata and returns ok=1 with wdata. Any accepted operation that changes the stored value clears all reservation bits. An operation that leaves the value equal to its old value keeps the bits, for example a write of the same value.
- R9: In each cycle req_ready is high for at most one requester, and only for one whose req_valid is high. The grant goes to the first valid requester after the one last granted, in cyclic index order. After reset, requester 0 comes first.
- R10: rsp_valid is high in exactly the cycle after each transfer, with rsp_id equal to the index of the requester that was granted.
- R11: The sequence load-linked by p, a write of a different value B, then a write restoring the original value A, followed by a store-conditional from p, makes that store-conditional fail with ok=0 and data A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one bit per requester |
| req_op | input | NREQ*3 | Opcode of each requester, 3 bits each, requester i in bits [3i+2:3i] |
| req_wdata | input | NREQ*DW | Value to store (write, store-conditional, new value of compare-and-swap) |
| req_cmp | input | NREQ*DW | Expected value for compare-and-swap |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_id | output | $clog2(NREQ) | Index of the requester the response belongs to |
| rsp_ok | output | 1 | Success flag |
| rsp_data | output | DW | Returned data value |

## Verification
The bench first sweeps every opcode from every requester over the four smallest data values. Because the values are so small, compare-and-swap matches and test-and-set on zero both occur often, and flag handling shows up through store-conditional outcomes. A long pseudo-random stream of mixed operations then follows, so that reservations are set and cleared by changing, non-changing and failed operations in many interleavings. Directed sequences separate the cases a single compare cannot tell apart: an A-B-A history that must defeat store-conditional but not compare-and-swap, a same-value write that must keep a reservation, and a same-value store-conditional that must still clear the other requesters' reservations. All-requester and two-requester contention patterns check the round-robin order and the response tags.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_LINK  = 3'd2,
    OP_COND  = 3'd3,
    OP_CAS   = 3'd4,
    OP_TAS   = 3'd5
  } op_e;
endpackage

// File: rtl/lw_rr_arbiter.sv
module lw_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any_gnt
);
  logic [IW-1:0] last_q;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      int unsigned cand;
      cand = (int'(last_q) + k) % N;
      if (!found && req[cand]) begin
        found     = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
    any_gnt = found;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IW'(N - 1);
    end else if (any_gnt) begin
      last_q <= gnt_idx;
    end
  end
endmodule

// File: rtl/lw_word_core.sv
module lw_word_core
  import lw_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [OP_W-1:0] op,
  input  logic [IW-1:0]   id,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   cmp,
  output logic [DW-1:0]   word_q,
  output logic [N-1:0]    resv_q,
  output logic            rsp_valid,
  output logic [IW-1:0]   rsp_id,
  output logic            rsp_ok,
  output logic [DW-1:0]   rsp_data
);
  logic [DW-1:0] nxt_word;
  logic [N-1:0]  nxt_resv;
  logic          res_ok;
  logic [DW-1:0] res_data;

  always_comb begin
    nxt_word = word_q;
    nxt_resv = resv_q;
    res_ok   = 1'b1;
    res_data = word_q;
    case (op)
      OP_WRITE: begin
        nxt_word = wdata;
        res_data = wdata;
      end
      OP_LINK: nxt_resv[id] = 1'b1;
      OP_COND: begin
        if (resv_q[id]) begin
          nxt_word = wdata;
          nxt_resv = '0;
          res_data = wdata;
        end else begin
          res_ok = 1'b0;
        end
      end
      OP_CAS: begin
        if (word_q == cmp) nxt_word = wdata;
        else               res_ok   = 1'b0;
      end
      OP_TAS: begin
        if (word_q == '0) nxt_word = DW'(1);
        else              res_ok   = 1'b0;
      end
      default: ;
    endcase
    if (nxt_word != word_q) nxt_resv = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      resv_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        word_q   <= nxt_word;
        resv_q   <= nxt_resv;
        rsp_id   <= id;
        rsp_ok   <= res_ok;
        rsp_data <= res_data;
      end
    end
  end
endmodule

// File: rtl/linked_word_unit.sv
module linked_word_unit
  import lw_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREQ)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREQ-1:0]      req_valid,
  output logic [NREQ-1:0]      req_ready,
  input  logic [NREQ*OP_W-1:0] req_op,
  input  logic [NREQ*DW-1:0]   req_wdata,
  input  logic [NREQ*DW-1:0]   req_cmp,
  output logic                 rsp_valid,
  output logic [IW-1:0]        rsp_id,
  output logic                 rsp_ok,
  output logic [DW-1:0]        rsp_data
);
  logic [IW-1:0] gnt_idx;
  logic          any_gnt;
  logic [DW-1:0] word_q;
  logic [NREQ-1:0] resv_q;

  lw_rr_arbiter #(.N(NREQ)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req_valid),
    .gnt     (req_ready),
    .gnt_idx (gnt_idx),
    .any_gnt (any_gnt)
  );

  lw_word_core #(.N(NREQ), .DW(DW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .fire      (any_gnt),
    .op        (req_op[gnt_idx*OP_W +: OP_W]),
    .id        (gnt_idx),
    .wdata     (req_wdata[gnt_idx*DW +: DW]),
    .cmp       (req_cmp[gnt_idx*DW +: DW]),
    .word_q    (word_q),
    .resv_q    (resv_q),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_ok    (rsp_ok),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
  parameter int NREQ = 4,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREQ)
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic            rsp_valid,
  input logic [IW-1:0]   rsp_id,
  input logic [IW-1:0]   gnt_idx,
  input logic [DW-1:0]   word_q,
  input logic [NREQ-1:0] resv_q
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(req_ready)); // R9
  AST_GRANT_HAS_VALID: assert property (@(posedge clk) disable iff (rst) (req_ready & ~req_valid) == '0); // R9
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst) (|req_ready) |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !(|req_ready) |=> !rsp_valid); // R10
  AST_RSP_TAG: assert property (@(posedge clk) disable iff (rst) (|req_ready) |=> (rsp_id == $past(gnt_idx))); // R10
  AST_CHANGE_CLEARS_RESV: assert property (@(posedge clk) disable iff (rst) (word_q != $past(word_q)) |-> (resv_q == '0)); // R8
endmodule

bind linked_word_unit lw_checker #(.NREQ(NREQ), .DW(DW)) u_chk (.*);

// File: tb/tb_linked_word_unit.sv
module tb_linked_word_unit;
  localparam int N  = 4;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N*3-1:0]  req_op = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N*DW-1:0] req_cmp = '0;
  logic            rsp_valid;
  logic [1:0]      rsp_id;
  logic            rsp_ok;
  logic [DW-1:0]   rsp_data;

  int nchecks = 0;
  int nfail = 0;
  logic done = 1'b0;

  logic [DW-1:0] mval;
  logic [N-1:0]  mres;

  always #5 clk = ~clk;

  linked_word_unit #(.NREQ(N), .DW(DW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking the response.
  task automatic do_op(input int id, input int op, input logic [DW-1:0] w,
                       input logic [DW-1:0] c, input string force_tag);
    logic          eok;
    logic [DW-1:0] ed, nv;
    logic [N-1:0]  nr;
    string         tag;
    eok = 1'b1; ed = mval; nv = mval; nr = mres;
    case (op)
      1: begin nv = w; ed = w; tag = "R8"; end
      2: begin nr[id] = 1'b1; tag = "R3"; end
      3: begin
        if (mres[id]) begin nv = w; nr = '0; ed = w; tag = "R4"; end
        else begin eok = 1'b0; tag = "R5"; end
      end
      4: begin if (mval == c) nv = w; else eok = 1'b0; tag = "R6"; end
      5: begin if (mval == '0) nv = 1; else eok = 1'b0; tag = "R7"; end
      default: tag = "R2";
    endcase
    if (nv != mval) nr = '0;
    if (force_tag != "") tag = force_tag;
    req_valid = '0;
    req_valid[id] = 1'b1;
    req_op[id*3 +: 3] = op[2:0];
    req_wdata[id*DW +: DW] = w;
    req_cmp[id*DW +: DW] = c;
    #1;
    chk("R9 single ready", 32'(req_ready), 32'(1 << id));
    @(negedge clk);
    req_valid = '0;
    chk("R10 rsp_valid", 32'(rsp_valid), 1);
    chk("R10 rsp_id", 32'(rsp_id), 32'(id));
    chk({tag, " ok"}, 32'(rsp_ok), 32'(eok));
    chk({tag, " data"}, 32'(rsp_data), 32'(ed));
    mval = nv;
    mres = nr;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mval = '0;
    mres = '0;
  endtask

  initial begin
    logic [15:0] lfsr;
    mval = '0;
    mres = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    do_op(0, 0, 8'h00, 8'h00, "R1");
    for (int i = 0; i < N; i++) do_op(i, 3, 8'h55, 8'h00, "R1");

    // Near-exhaustive sweep: every opcode, every requester, small values
    for (int op = 0; op < 8; op++)
      for (int id = 0; id < N; id++)
        for (int w = 0; w < 4; w++)
          do_op(id, op, DW'(w), DW'(3 - w), "");

    // Pseudo-random mixed stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 800; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(int'(lfsr[1:0]), int'(lfsr[4:2]), DW'(lfsr[6:5]), DW'(lfsr[8:7]), "");
    end

    // R11: A-B-A defeats store-conditional, not compare-and-swap
    do_op(0, 1, 8'h05, 8'h00, "R8");
    do_op(1, 2, 8'h00, 8'h00, "R3");
    do_op(2, 1, 8'h09, 8'h00, "R8");
    do_op(3, 1, 8'h05, 8'h00, "R8");
    do_op(1, 3, 8'h77, 8'h00, "R11");
    do_op(2, 4, 8'h07, 8'h05, "R6");

    // R8: same-value write keeps a reservation
    do_op(2, 2, 8'h00, 8'h00, "R3");
    do_op(0, 1, 8'h07, 8'h00, "R8");
    do_op(2, 3, 8'h0A, 8'h00, "R8");

    // R4: same-value store-conditional still clears other reservations
    do_op(0, 2, 8'h00, 8'h00, "R3");
    do_op(1, 2, 8'h00, 8'h00, "R3");
    do_op(0, 3, 8'h0A, 8'h00, "R4");
    do_op(1, 3, 8'h0B, 8'h00, "R4");

    // R9/R10: round-robin with all requesters busy, starting after reset
    do_reset();
    req_op = '0;
    req_valid = 4'hF;
    #1;
    chk("R9 first grant after reset", 32'(req_ready), 32'h1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R10 rsp_valid under load", 32'(rsp_valid), 1);
      chk("R9 round-robin order", 32'(rsp_id), 32'(k % N));
      #1;
      chk("R9 next ready", 32'(req_ready), 32'(1 << ((k + 1) % N)));
    end
    @(negedge clk);
    req_valid = 4'b1010;
    #1;
    chk("R9 subset first grant", 32'(req_ready), 32'h2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 subset order", 32'(rsp_id), (k % 2 == 0) ? 1 : 3);
    end
    req_valid = '0;
    @(negedge clk);
    chk("R10 no response without grant", 32'(rsp_valid), 0);
    chk("R2 data after reads", 32'(rsp_data), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule